// File: doc/BRIEF.md
# Mixed-Drive Port Register Bank

This block keeps the direction and output-data state of eight general-purpose lines split into two groups of four. Group A lines can only sink current or float, so their pad interface is an enable that pulls the line low. Group B lines have full push-pull drivers. The block turns its registers into per-line pad enable and pad level signals. It also keeps two input registers that hold synchronised copies of the line levels and are refreshed on a sample strobe.

A serial-bus front end performs register writes through a select code, a four-bit data nibble and a one-cycle strobe. The front end has already taken the nibble from the upper half of the received byte. A board strap picks the output defaults. The block takes the strap value in every cycle in which power-on reset is held, and ignores it at all other times. The strap lets a board power up with all lines held low, or with all lines high or released.

Top module: `mixdrv_port_bank`

## Requirements
- R1: While power-on reset is held, and after it is released, both direction registers are 0000, so every line of both groups is an output (b_oe = 1111).
- R2: A reset taken with strap low clears both output registers. Every group A line is then pulled low (a_oe = 1111) and every group B line drives 0.
- R3: A reset taken with strap high sets both output registers to 1111. Every group A line is then released (a_oe = 0000) and every group B line drives 1.
- R4: A write takes effect on the clock edge where wr_stb is high, and only on that edge. wr_sel selects the target: 0 is the group A output register, 1 is the group B output register, 2 is the group A direction register and 3 is the group B direction register. Bit i of wr_nib goes to line i. When wr_stb is low, sel and data have no effect.
- R5: A direction bit of 1 makes the line an input and disables its driver. A direction bit of 0 makes the line an output. For group B this means b_oe[i] = NOT dir[i].
- R6: A group A line is pulled low (a_oe[i] = 1) only when it is an output and its output bit is 0. Writing 1 releases the line. a_lvl is always 0.
- R7: When a group B line is an output, b_lvl[i] equals its output bit. When the line is an input, b_lvl[i] is 0.
- R8: in_a and in_b reset to 0. At an edge with smp_stb high they load the pin levels seen at the edge SYNC_STAGES edges earlier, which is two edges by default. At all other edges they hold their value.
- R9: A change on strap while power-on reset is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| strap | input | 1 | Board strap that selects the output defaults while reset is held |
| wr_stb | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register select code |
| wr_nib | input | 4 | Write data, bit i for line i |
| smp_stb | input | 1 | Input register refresh strobe |
| pin_a | input | 4 | Group A line levels |
| pin_b | input | 4 | Group B line levels |
| a_oe | output | 4 | Group A pull-low enable |
| a_lvl | output | 4 | Group A drive level (always low) |
| b_oe | output | 4 | Group B driver enable |
| b_lvl | output | 4 | Group B drive level |
| in_a | output | 4 | Sampled group A levels |
| in_b | output | 4 | Sampled group B levels |

## Verification
Every pad output is a combinational function of the direction and output registers. A corrupted register bit therefore shows on a_oe, b_oe or b_lvl in the first cycle after the bad edge, unless the direction bit hides the output bit. For that reason the bench writes output data while some lines are inputs and then turns those lines back into outputs, so that stale output bits become visible. A wrong synchroniser depth or a wrong capture condition shows on in_a or in_b at the first strobe after a pin change. The bench places strobes at several distances from the pin changes so that a depth off by one edge cannot go unnoticed.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    typedef enum logic [1:0] {
        SEL_A_OUT = 2'd0,
        SEL_B_OUT = 2'd1,
        SEL_A_DIR = 2'd2,
        SEL_B_DIR = 2'd3
    } mdp_sel_e;

    typedef enum logic {
        DRV_OPEN_DRAIN = 1'b0,
        DRV_PUSH_PULL  = 1'b1
    } mdp_drive_e;

    typedef struct packed {
        logic en;
        logic lvl;
    } mdp_pad_t;

    // Pad control for one line from its direction and output bits.
    function automatic mdp_pad_t pad_of(mdp_drive_e kind, logic is_in, logic val);
        mdp_pad_t p;
        if (kind == DRV_OPEN_DRAIN) begin
            p.en  = ~is_in & ~val;
            p.lvl = 1'b0;
        end else begin
            p.en  = ~is_in;
            p.lvl = ~is_in & val;
        end
        return p;
    endfunction

endpackage

// File: rtl/mdp_port_group.sv
module mdp_port_group
    import mdp_pkg::*;
#(
    parameter int         W       = 4,
    parameter mdp_drive_e KIND    = DRV_PUSH_PULL,
    parameter mdp_sel_e   OUT_SEL = SEL_B_OUT,
    parameter mdp_sel_e   DIR_SEL = SEL_B_DIR
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic         strap,
    input  logic         wr_stb,
    input  mdp_sel_e     wr_sel,
    input  logic [W-1:0] wr_nib,
    output logic [W-1:0] pad_en,
    output logic [W-1:0] pad_lvl
);

    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            out_q <= {W{strap}};
            dir_q <= '0;
        end else if (wr_stb) begin
            if (wr_sel == OUT_SEL) out_q <= wr_nib;
            if (wr_sel == DIR_SEL) dir_q <= wr_nib;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        mdp_pad_t pad;
        assign pad        = pad_of(KIND, dir_q[i], out_q[i]);
        assign pad_en[i]  = pad.en;
        assign pad_lvl[i] = pad.lvl;
    end

endmodule

// File: rtl/mdp_in_sampler.sv
module mdp_in_sampler #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic         smp_stb,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cap_q
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] sync_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (por_rst)     sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= pin_i;
            else             sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst)      cap_q <= '0;
        else if (smp_stb) cap_q <= sync_q[LAST];
    end

endmodule

// File: rtl/mixdrv_port_bank.sv
module mixdrv_port_bank
    import mdp_pkg::*;
#(
    parameter int PIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             strap,
    input  logic             wr_stb,
    input  logic [1:0]       wr_sel,
    input  logic [PIN_W-1:0] wr_nib,
    input  logic             smp_stb,
    input  logic [PIN_W-1:0] pin_a,
    input  logic [PIN_W-1:0] pin_b,
    output logic [PIN_W-1:0] a_oe,
    output logic [PIN_W-1:0] a_lvl,
    output logic [PIN_W-1:0] b_oe,
    output logic [PIN_W-1:0] b_lvl,
    output logic [PIN_W-1:0] in_a,
    output logic [PIN_W-1:0] in_b
);

    mdp_sel_e sel_e;
    assign sel_e = mdp_sel_e'(wr_sel);

    mdp_port_group #(
        .W(PIN_W), .KIND(DRV_OPEN_DRAIN), .OUT_SEL(SEL_A_OUT), .DIR_SEL(SEL_A_DIR)
    ) u_grp_a (
        .clk(clk), .por_rst(por_rst), .strap(strap), .wr_stb(wr_stb),
        .wr_sel(sel_e), .wr_nib(wr_nib), .pad_en(a_oe), .pad_lvl(a_lvl)
    );

    mdp_port_group #(
        .W(PIN_W), .KIND(DRV_PUSH_PULL), .OUT_SEL(SEL_B_OUT), .DIR_SEL(SEL_B_DIR)
    ) u_grp_b (
        .clk(clk), .por_rst(por_rst), .strap(strap), .wr_stb(wr_stb),
        .wr_sel(sel_e), .wr_nib(wr_nib), .pad_en(b_oe), .pad_lvl(b_lvl)
    );

    mdp_in_sampler #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_smp_a (
        .clk(clk), .por_rst(por_rst), .smp_stb(smp_stb), .pin_i(pin_a), .cap_q(in_a)
    );

    mdp_in_sampler #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_smp_b (
        .clk(clk), .por_rst(por_rst), .smp_stb(smp_stb), .pin_i(pin_b), .cap_q(in_b)
    );

endmodule

// File: rtl/mixdrv_port_bank_chk.sv
module mixdrv_port_bank_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         por_rst,
    input logic         strap,
    input logic         wr_stb,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_nib,
    input logic         smp_stb,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] b_lvl,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b
);

    // R1 and R3: reset leaves every line an output, with group B at the strap level
    assert_reset_dflt_R1: assert property (@(posedge clk)
        por_rst |=> (b_oe == {W{1'b1}}) && (b_lvl == {W{$past(strap)}}));

    // R5: a line written as an input has its driver disabled
    assert_dir_b_R5: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && wr_sel == 2'd3) |=> (b_oe == ~$past(wr_nib)));

    assert_dir_a_R5: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && wr_sel == 2'd2) |=> ((a_oe & $past(wr_nib)) == '0));

    // R6: writing 1 to a group A output bit releases the line
    assert_od_release_R6: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && wr_sel == 2'd0) |=> ((a_oe & $past(wr_nib)) == '0));

    // R7: group B output lines follow the written level
    assert_pp_level_R7: assert property (@(posedge clk) disable iff (por_rst)
        (wr_stb && wr_sel == 2'd1) |=> ((b_lvl & b_oe) == ($past(wr_nib) & b_oe)));

    // R8: the input registers hold when no sample strobe is given
    assert_in_hold_R8: assert property (@(posedge clk) disable iff (por_rst)
        !smp_stb |=> ($stable(in_a) && $stable(in_b)));

    // R9: without a write the pad controls stay put, whatever the strap does
    assert_strap_ignored_R9: assert property (@(posedge clk) disable iff (por_rst)
        !wr_stb |=> ($stable(a_oe) && $stable(b_oe) && $stable(b_lvl)));

endmodule

bind mixdrv_port_bank mixdrv_port_bank_chk #(.W(PIN_W)) u_chk (
    .clk(clk), .por_rst(por_rst), .strap(strap), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .wr_nib(wr_nib), .smp_stb(smp_stb),
    .a_oe(a_oe), .b_oe(b_oe), .b_lvl(b_lvl), .in_a(in_a), .in_b(in_b)
);

// File: tb/sim_mixdrv_port_bank.sv
`timescale 1ns/1ps
module sim_mixdrv_port_bank;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int DEPTH      = 2;

    logic         clk = 1'b0;
    logic         por_rst, strap, wr_stb, smp_stb;
    logic [1:0]   wr_sel;
    logic [W-1:0] wr_nib, pin_a, pin_b;
    logic [W-1:0] a_oe, a_lvl, b_oe, b_lvl, in_a, in_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_ok = 1'b0;
    bit done = 1'b0;

    // reference state
    logic [W-1:0] m_oa, m_ob, m_da, m_db, m_ia, m_ib;
    logic [W-1:0] ha[$];
    logic [W-1:0] hb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mixdrv_port_bank #(.PIN_W(W), .SYNC_STAGES(DEPTH)) u0 (
        .clk(clk), .por_rst(por_rst), .strap(strap), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .wr_nib(wr_nib), .smp_stb(smp_stb),
        .pin_a(pin_a), .pin_b(pin_b), .a_oe(a_oe), .a_lvl(a_lvl),
        .b_oe(b_oe), .b_lvl(b_lvl), .in_a(in_a), .in_b(in_b)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (por_rst) begin
            m_oa = {W{strap}};
            m_ob = {W{strap}};
            m_da = '0; m_db = '0; m_ia = '0; m_ib = '0;
            ha = {};
            hb = {};
            for (int k = 0; k < DEPTH; k++) begin
                ha.push_back('0);
                hb.push_back('0);
            end
        end else begin
            if (wr_stb) begin
                case (wr_sel)
                    2'd0: m_oa = wr_nib;
                    2'd1: m_ob = wr_nib;
                    2'd2: m_da = wr_nib;
                    default: m_db = wr_nib;
                endcase
            end
            if (smp_stb) begin
                m_ia = ha[DEPTH-1];
                m_ib = hb[DEPTH-1];
            end
            ha.push_front(pin_a); void'(ha.pop_back());
            hb.push_front(pin_b); void'(hb.pop_back());
        end
        model_ok = 1'b1;
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (model_ok && !done) begin
            check("R6 a_oe",  a_oe,  ~m_da & ~m_oa);
            check("R6 a_lvl", a_lvl, '0);
            check("R5 b_oe",  b_oe,  ~m_db);
            check("R7 b_lvl", b_lvl, m_ob & ~m_db);
            check("R8 in_a",  in_a,  m_ia);
            check("R8 in_b",  in_b,  m_ib);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [W-1:0] d);
        wr_sel = s; wr_nib = d; wr_stb = 1'b1;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic do_reset(logic s);
        por_rst = 1'b1; strap = s;
        repeat (3) tick();
        por_rst = 1'b0;
    endtask

    initial begin
        por_rst = 1'b1; strap = 1'b0; wr_stb = 1'b0; smp_stb = 1'b0;
        wr_sel = '0; wr_nib = '0; pin_a = '0; pin_b = '0;

        // strap low defaults
        do_reset(1'b0);
        check("R1 dir reset", b_oe, 4'hF);
        check("R2 A pulled low", a_oe, 4'hF);
        check("R2 B drives 0", b_lvl, 4'h0);
        check("R8 in reset", in_a | in_b, 4'h0);

        // strap change after reset
        strap = 1'b1; repeat (3) tick();
        check("R9 strap ignored A", a_oe, 4'hF);
        check("R9 strap ignored B", b_lvl, 4'h0);
        strap = 1'b0;

        // writes without strobe
        wr_sel = 2'd1; wr_nib = 4'hF; tick();
        wr_sel = 2'd3; wr_nib = 4'hF; tick();
        check("R4 no strobe B", b_lvl, 4'h0);
        check("R4 no strobe oe", b_oe, 4'hF);

        // each register
        wr(2'd1, 4'b1010); check("R4 R7 B out", b_lvl, 4'b1010);
        wr(2'd0, 4'b0110); check("R4 R6 A out", a_oe, 4'b1001);
        wr(2'd3, 4'b1100); check("R5 B dir", b_oe, 4'b0011);
        check("R7 B input masked", b_lvl, 4'b0010);
        wr(2'd2, 4'b0011); check("R5 A dir", a_oe, 4'b1000);
        wr(2'd1, 4'b0101); wr(2'd3, 4'b0000);
        check("R7 B hidden bits", b_lvl, 4'b0101);

        // input sampling at varying distance from pin changes
        for (int k = 0; k < 6; k++) begin
            pin_a = 4'(k * 3 + 1); pin_b = 4'(~(k * 5));
            repeat (k % 3) tick();
            smp_stb = 1'b1; tick(); smp_stb = 1'b0;
            tick();
        end
        pin_a = 4'h9; pin_b = 4'h6;
        repeat (4) tick();
        smp_stb = 1'b1; tick(); smp_stb = 1'b0;
        check("R8 settled A", in_a, 4'h9);
        check("R8 settled B", in_b, 4'h6);

        // strap high defaults
        do_reset(1'b1);
        check("R3 A released", a_oe, 4'h0);
        check("R3 B drives 1", b_lvl, 4'hF);
        check("R1 dir reset strap high", b_oe, 4'hF);
        check("R8 in cleared", in_a | in_b, 4'h0);
        strap = 1'b0; repeat (2) tick();
        check("R9 strap low ignored", b_lvl, 4'hF);

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            wr_stb  = 1'($urandom_range(0, 2) == 0);
            wr_sel  = 2'($urandom);
            wr_nib  = 4'($urandom);
            smp_stb = 1'($urandom_range(0, 3) == 0);
            strap   = 1'($urandom);
            pin_a   = 4'($urandom);
            pin_b   = 4'($urandom);
            tick();
        end
        wr_stb = 1'b0; smp_stb = 1'b0;
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule